// File: doc/BRIEF.md
# Nibble-Addressed Call and Register Stack Engine

This block runs a downward-growing stack that lives in a 4-bit-wide data memory. It serves four operations that all share one 8-bit stack pointer. A call stores a four-nibble frame that holds the 13-bit return address and the carry and zero flags. A return reads that frame back, and it restores the flags only when the operation asks for it. A register push stores one 8-bit register pair as two nibbles, and a register pop loads the pair back.

The engine moves one nibble per clock cycle over a memory port with a synchronous read. It raises busy while a sequence is running and pulses done when the sequence finishes. The surrounding core drives the operation code, the return address, the flags and the three register pairs. It takes back the reloaded address, the flags and the popped byte through load strobes that are valid in the done cycle.

Top module: `nib_stack_engine`

## Requirements
- R1: After reset, sp equals the SP_TOP parameter, and busy, done, err and mem_we are all low.
- R2: A call (op_kind 2'b00) writes four nibbles to addresses sp-4, sp-3, sp-2 and sp-1, one per cycle, in the order PC[3:0], PC[7:4], PC[11:8], {CF, ZF, 1'b0, PC[12]}. The first write lands at the edge after acceptance. sp drops by 4 in the cycle that done is high.
- R3: A register push (op_kind 2'b10) stores the pair picked by op_sel: 0 is HL, 1 is XY, 2 is AE. The low nibble goes to sp-2 and the high nibble goes to sp-1. sp drops by 2 in the cycle that done is high.
- R4: A register pop (op_kind 2'b11) raises sp by 2 at the acceptance edge. It then reads the low nibble from the old sp and the high nibble from old sp+1. In the done cycle it presents the byte on pop_data and drives reg_load, which is one-hot, with bit op_sel set.
- R5: A return (op_kind 2'b01) raises sp by 4 at the acceptance edge. It rebuilds the 13-bit PC from the four nibbles stored by a call and pulses ret_load in the done cycle.
- R6: flags_load pulses together with ret_load only when op_restore was 1 at acceptance. ret_cf and ret_zf then carry the stored flags.
- R7: A push or pop with op_sel 2'b11 pulses err for one cycle. It leaves busy low, writes no memory and leaves sp unchanged.
- R8: sp and all frame addresses wrap modulo 256.
- R9: op_valid is taken only while busy is low. A request offered while busy has no effect. done is a one-cycle pulse with busy low.
- R10: After acceptance, done rises N+1 cycles later for writing operations and N+2 cycles later for reading operations, where N is the frame length in nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 00 call, 01 return, 10 push, 11 pop |
| op_restore | input | 1 | Return also restores flags |
| op_sel | input | 2 | Register pair select: 0 HL, 1 XY, 2 AE |
| call_pc | input | 13 | Return address stored by a call |
| call_cf | input | 1 | Carry flag stored by a call |
| call_zf | input | 1 | Zero flag stored by a call |
| hl_in | input | 8 | HL pair value |
| xy_in | input | 8 | XY pair value |
| ae_in | input | 8 | AE pair value |
| mem_addr | output | 8 | Nibble memory address |
| mem_we | output | 1 | Nibble memory write enable |
| mem_wdata | output | 4 | Nibble memory write data |
| mem_rdata | input | 4 | Nibble memory read data, one cycle after the address |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, one-cycle pulse |
| err | output | 1 | Illegal register select, one-cycle pulse |
| ret_pc | output | 13 | Reloaded return address |
| ret_cf | output | 1 | Reloaded carry flag |
| ret_zf | output | 1 | Reloaded zero flag |
| ret_load | output | 1 | Load strobe for ret_pc |
| flags_load | output | 1 | Load strobe for ret_cf and ret_zf |
| pop_data | output | 8 | Popped register pair byte |
| reg_load | output | 3 | One-hot load strobe per register pair |

## Verification
Two calls use different addresses and flag patterns, so every nibble position and both flag bits take both values; a swapped nibble order or a swapped flag would show in the logged writes. Pushes of all three pairs are then popped into different pairs in reverse order, which separates selector decoding from frame addressing and shows that the two frame sizes nest on one pointer. A return without flag restore and one with flag restore tell the optional flag path apart. Starting the pointer at 2 makes the first frame straddle address zero and the return wrap back up. A request offered during a busy call and the illegal select on push and pop must leave the write log and the pointer untouched.

// File: rtl/nse_pkg.sv
package nse_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'b00,
    OP_RET  = 2'b01,
    OP_PUSH = 2'b10,
    OP_POP  = 2'b11
  } op_e;

  function automatic logic op_writes(input op_e k);
    return (k == OP_CALL) || (k == OP_PUSH);
  endfunction

  function automatic logic op_is_reg(input op_e k);
    return (k == OP_PUSH) || (k == OP_POP);
  endfunction

endpackage

// File: rtl/nse_regsel.sv
module nse_regsel #(
  parameter int DW   = 8,
  parameter int NREG = 3,
  parameter int SW   = 2
) (
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] pair0,
  input  logic [DW-1:0] pair1,
  input  logic [DW-1:0] pair2,
  output logic [DW-1:0] rbyte,
  output logic          illegal
);

  logic [DW-1:0] bank [NREG];

  assign bank[0] = pair0;
  assign bank[1] = pair1;
  assign bank[2] = pair2;

  always_comb begin
    illegal = (int'(sel) >= NREG);
    rbyte   = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(sel) == i) rbyte = bank[i];
    end
  end

endmodule

// File: rtl/nse_frame.sv
module nse_frame
  import nse_pkg::*;
#(
  parameter int PCW  = 13,
  parameter int DW   = 8,
  parameter int FW   = 16,
  parameter int NREG = 3,
  parameter int SW   = 2
) (
  input  op_e            kind_in,
  input  logic [PCW-1:0] pc_in,
  input  logic           cf_in,
  input  logic           zf_in,
  input  logic [DW-1:0]  rbyte_in,
  output logic [FW-1:0]  frame_out,
  input  logic [FW-1:0]  res_word,
  input  op_e            res_kind,
  input  logic           res_restore,
  input  logic [SW-1:0]  res_sel,
  input  logic           res_done,
  output logic [PCW-1:0] ret_pc,
  output logic           ret_cf,
  output logic           ret_zf,
  output logic           ret_load,
  output logic           flags_load,
  output logic [DW-1:0]  pop_data,
  output logic [NREG-1:0] reg_load
);

  localparam int PADW = FW - PCW - 2;

  // Frame packing: flags sit in the top nibble above the PC
  always_comb begin
    if (op_is_reg(kind_in)) frame_out = {{(FW-DW){1'b0}}, rbyte_in};
    else                    frame_out = {cf_in, zf_in, {PADW{1'b0}}, pc_in};
  end

  // Frame unpacking from the registered result word
  assign ret_pc     = res_word[PCW-1:0];
  assign ret_cf     = res_word[FW-1];
  assign ret_zf     = res_word[FW-2];
  assign pop_data   = res_word[DW-1:0];
  assign ret_load   = res_done && (res_kind == OP_RET);
  assign flags_load = res_done && (res_kind == OP_RET) && res_restore;

  for (genvar g = 0; g < NREG; g++) begin : g_load
    assign reg_load[g] = res_done && (res_kind == OP_POP) && (int'(res_sel) == g);
  end

endmodule

// File: rtl/nse_seq.sv
module nse_seq
  import nse_pkg::*;
#(
  parameter int            AW         = 8,
  parameter int            NIB_W      = 4,
  parameter int            FRAME_NIBS = 4,
  parameter int            REG_NIBS   = 2,
  parameter int            SW         = 2,
  parameter logic [AW-1:0] SP_TOP     = 8'hC0,
  localparam int           FW         = NIB_W * FRAME_NIBS,
  localparam int           CW         = $clog2(FRAME_NIBS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  op_e              op_kind,
  input  logic             op_restore,
  input  logic [SW-1:0]    op_sel,
  input  logic             reg_illegal,
  input  logic [FW-1:0]    frame_in,
  input  logic [NIB_W-1:0] mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [NIB_W-1:0] mem_wdata,
  output logic [AW-1:0]    sp,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [FW-1:0]    res_word,
  output op_e              res_kind,
  output logic             res_restore,
  output logic [SW-1:0]    res_sel
);

  logic [FW-1:0] frame_q;
  logic [FW-1:0] acc_q;
  logic [FW-1:0] full_w;
  logic [AW-1:0] base_q;
  logic [CW-1:0] iss_q;
  logic [CW-1:0] cap_q;
  logic [CW-1:0] len_q;
  logic          wr_q;
  logic          pend1_q;
  logic          pend2_q;

  logic [CW-1:0] len_now;
  logic          wr_now;
  logic [AW-1:0] base_now;

  always_comb begin
    wr_now   = op_writes(op_kind);
    len_now  = op_is_reg(op_kind) ? CW'(REG_NIBS) : CW'(FRAME_NIBS);
    base_now = wr_now ? (sp - AW'(len_now)) : sp;
    full_w   = {mem_rdata, acc_q[FW-1:NIB_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp          <= SP_TOP;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      frame_q     <= '0;
      acc_q       <= '0;
      base_q      <= '0;
      iss_q       <= '0;
      cap_q       <= '0;
      len_q       <= '0;
      wr_q        <= 1'b0;
      pend1_q     <= 1'b0;
      pend2_q     <= 1'b0;
      res_word    <= '0;
      res_kind    <= OP_CALL;
      res_restore <= 1'b0;
      res_sel     <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        mem_we <= 1'b0;
        if (op_valid) begin
          if (op_is_reg(op_kind) && reg_illegal) begin
            err <= 1'b1;
          end else begin
            busy        <= 1'b1;
            res_kind    <= op_kind;
            res_restore <= op_restore;
            res_sel     <= op_sel;
            frame_q     <= frame_in;
            len_q       <= len_now;
            wr_q        <= wr_now;
            base_q      <= base_now;
            iss_q       <= CW'(1);
            cap_q       <= '0;
            mem_addr    <= base_now;
            mem_we      <= wr_now;
            mem_wdata   <= frame_in[NIB_W-1:0];
            pend1_q     <= !wr_now;
            pend2_q     <= 1'b0;
            if (!wr_now) sp <= sp + AW'(len_now);
          end
        end
      end else if (wr_q) begin
        if (iss_q < len_q) begin
          mem_addr  <= base_q + AW'(iss_q);
          mem_wdata <= frame_q[int'(iss_q)*NIB_W +: NIB_W];
          iss_q     <= iss_q + CW'(1);
        end else begin
          mem_we <= 1'b0;
          done   <= 1'b1;
          busy   <= 1'b0;
          sp     <= base_q;
        end
      end else begin
        pend1_q <= (iss_q < len_q);
        pend2_q <= pend1_q;
        if (iss_q < len_q) begin
          mem_addr <= base_q + AW'(iss_q);
          iss_q    <= iss_q + CW'(1);
        end
        if (pend2_q) begin
          acc_q <= full_w;
          cap_q <= cap_q + CW'(1);
          if (cap_q == len_q - CW'(1)) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            pend1_q <= 1'b0;
            pend2_q <= 1'b0;
            if (len_q == CW'(FRAME_NIBS)) res_word <= full_w;
            else res_word <= full_w >> (NIB_W * (FRAME_NIBS - REG_NIBS));
          end
        end
      end
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R9
  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst) err |-> (!busy && !mem_we && sp == $past(sp))); // R7
  AST_CALL_SP_STEP: assert property (@(posedge clk) disable iff (rst) (done && res_kind == OP_CALL) |-> sp == $past(sp) - AW'(FRAME_NIBS)); // R2
  AST_RET_SP_STEP: assert property (@(posedge clk) disable iff (rst) (busy && !$past(busy) && res_kind == OP_RET) |-> sp == $past(sp) + AW'(FRAME_NIBS)); // R5

endmodule

// File: rtl/nib_stack_engine.sv
module nib_stack_engine
  import nse_pkg::*;
#(
  parameter int            AW         = 8,
  parameter int            NIB_W      = 4,
  parameter int            PCW        = 13,
  parameter int            DW         = 8,
  parameter int            FRAME_NIBS = 4,
  parameter int            REG_NIBS   = 2,
  parameter int            NREG       = 3,
  parameter logic [AW-1:0] SP_TOP     = 8'hC0,
  localparam int           FW         = NIB_W * FRAME_NIBS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic             op_restore,
  input  logic [1:0]       op_sel,
  input  logic [PCW-1:0]   call_pc,
  input  logic             call_cf,
  input  logic             call_zf,
  input  logic [DW-1:0]    hl_in,
  input  logic [DW-1:0]    xy_in,
  input  logic [DW-1:0]    ae_in,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [NIB_W-1:0] mem_wdata,
  input  logic [NIB_W-1:0] mem_rdata,
  output logic [AW-1:0]    sp,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [PCW-1:0]   ret_pc,
  output logic             ret_cf,
  output logic             ret_zf,
  output logic             ret_load,
  output logic             flags_load,
  output logic [DW-1:0]    pop_data,
  output logic [NREG-1:0]  reg_load
);

  op_e           kind_w;
  logic [DW-1:0] rbyte_w;
  logic          illegal_w;
  logic [FW-1:0] frame_w;
  logic [FW-1:0] res_word_w;
  op_e           res_kind_w;
  logic          res_restore_w;
  logic [1:0]    res_sel_w;

  assign kind_w = op_e'(op_kind);

  nse_regsel #(.DW(DW), .NREG(NREG), .SW(2)) u_regsel (
    .sel     (op_sel),
    .pair0   (hl_in),
    .pair1   (xy_in),
    .pair2   (ae_in),
    .rbyte   (rbyte_w),
    .illegal (illegal_w)
  );

  nse_seq #(
    .AW(AW), .NIB_W(NIB_W), .FRAME_NIBS(FRAME_NIBS),
    .REG_NIBS(REG_NIBS), .SW(2), .SP_TOP(SP_TOP)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_kind     (kind_w),
    .op_restore  (op_restore),
    .op_sel      (op_sel),
    .reg_illegal (illegal_w),
    .frame_in    (frame_w),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .sp          (sp),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .res_word    (res_word_w),
    .res_kind    (res_kind_w),
    .res_restore (res_restore_w),
    .res_sel     (res_sel_w)
  );

  nse_frame #(.PCW(PCW), .DW(DW), .FW(FW), .NREG(NREG), .SW(2)) u_frame (
    .kind_in     (kind_w),
    .pc_in       (call_pc),
    .cf_in       (call_cf),
    .zf_in       (call_zf),
    .rbyte_in    (rbyte_w),
    .frame_out   (frame_w),
    .res_word    (res_word_w),
    .res_kind    (res_kind_w),
    .res_restore (res_restore_w),
    .res_sel     (res_sel_w),
    .res_done    (done),
    .ret_pc      (ret_pc),
    .ret_cf      (ret_cf),
    .ret_zf      (ret_zf),
    .ret_load    (ret_load),
    .flags_load  (flags_load),
    .pop_data    (pop_data),
    .reg_load    (reg_load)
  );

  AST_FLAGS_NEED_RET: assert property (@(posedge clk) disable iff (rst) flags_load |-> ret_load); // R6
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(reg_load)); // R4
  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) ret_load |-> (reg_load == '0)); // R4

endmodule

// File: tb/nib_stack_engine_tb_top.sv
module nib_stack_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        op_restore = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [12:0] call_pc = '0;
  logic        call_cf = 1'b0;
  logic        call_zf = 1'b0;
  logic [7:0]  hl_in = '0, xy_in = '0, ae_in = '0;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [3:0]  mem_wdata;
  logic [3:0]  mem_rdata;
  logic [7:0]  sp;
  logic        busy, done, err;
  logic [12:0] ret_pc;
  logic        ret_cf, ret_zf, ret_load, flags_load;
  logic [7:0]  pop_data;
  logic [2:0]  reg_load;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nib_stack_engine #(.SP_TOP(8'h02)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_restore(op_restore), .op_sel(op_sel), .call_pc(call_pc),
    .call_cf(call_cf), .call_zf(call_zf), .hl_in(hl_in), .xy_in(xy_in),
    .ae_in(ae_in), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp(sp), .busy(busy),
    .done(done), .err(err), .ret_pc(ret_pc), .ret_cf(ret_cf),
    .ret_zf(ret_zf), .ret_load(ret_load), .flags_load(flags_load),
    .pop_data(pop_data), .reg_load(reg_load)
  );

  // Nibble memory with synchronous read, plus a write log
  logic [3:0] mem [256];
  logic [7:0] log_a [64];
  logic [3:0] log_d [64];
  int         wn = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (wn < 64) begin
        log_a[wn] <= mem_addr;
        log_d[wn] <= mem_wdata;
      end
      wn <= wn + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one operation, return latency, sp after acceptance and write start index
  task automatic issue(input logic [1:0] k, input logic rs, input logic [1:0] s,
                       output int lat, output logic [7:0] sp1, output int w0);
    @(negedge clk);
    w0 = wn;
    op_valid = 1'b1; op_kind = k; op_restore = rs; op_sel = s;
    @(negedge clk);
    op_valid = 1'b0;
    sp1 = sp;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic chk_write(input int idx, input logic [7:0] a, input logic [3:0] d, input string req);
    chk(log_a[idx] == a, req, log_a[idx], a);
    chk(log_d[idx] == d, req, log_d[idx], d);
  endtask

  task automatic t_reset();
    chk(sp == 8'h02, "R1 sp", sp, 8'h02);
    chk(!busy && !done && !err && !mem_we, "R1 idle", {busy, done, err, mem_we}, 0);
  endtask

  task automatic t_call(input logic [12:0] pc, input logic cf, input logic zf);
    int lat; logic [7:0] s0, sp1; int w0;
    s0 = sp;
    call_pc = pc; call_cf = cf; call_zf = zf;
    issue(2'b00, 1'b0, 2'b00, lat, sp1, w0);
    chk(lat == 5, "R10 call latency", lat, 5);
    chk(wn - w0 == 4, "R2 write count", wn - w0, 4);
    chk_write(w0 + 0, s0 - 8'd4, pc[3:0], "R2 nib0");
    chk_write(w0 + 1, s0 - 8'd3, pc[7:4], "R2 nib1");
    chk_write(w0 + 2, s0 - 8'd2, pc[11:8], "R2 nib2");
    chk_write(w0 + 3, s0 - 8'd1, {cf, zf, 1'b0, pc[12]}, "R2 nib3");
    chk(sp == s0 - 8'd4, "R2 R8 sp", sp, s0 - 8'd4);
    @(negedge clk);
    chk(!done, "R9 done pulse", done, 0);
  endtask

  task automatic t_push(input logic [1:0] s, input logic [7:0] v);
    int lat; logic [7:0] s0, sp1; int w0;
    s0 = sp;
    hl_in = 8'h00; xy_in = 8'h00; ae_in = 8'h00;
    if (s == 2'd0) hl_in = v; else if (s == 2'd1) xy_in = v; else ae_in = v;
    issue(2'b10, 1'b0, s, lat, sp1, w0);
    chk(lat == 3, "R10 push latency", lat, 3);
    chk(wn - w0 == 2, "R3 write count", wn - w0, 2);
    chk_write(w0 + 0, s0 - 8'd2, v[3:0], "R3 low nibble");
    chk_write(w0 + 1, s0 - 8'd1, v[7:4], "R3 high nibble");
    chk(sp == s0 - 8'd2, "R3 sp", sp, s0 - 8'd2);
  endtask

  task automatic t_pop(input logic [1:0] s, input logic [7:0] v);
    int lat; logic [7:0] s0, sp1; int w0;
    s0 = sp;
    issue(2'b11, 1'b0, s, lat, sp1, w0);
    chk(sp1 == s0 + 8'd2, "R4 sp first", sp1, s0 + 8'd2);
    chk(lat == 4, "R10 pop latency", lat, 4);
    chk(pop_data == v, "R4 pop data", pop_data, v);
    chk(reg_load == (3'b001 << s), "R4 reg_load", reg_load, 3'b001 << s);
    chk(!ret_load, "R4 no ret_load", ret_load, 0);
    @(negedge clk);
    chk(reg_load == 3'b000, "R9 reg_load pulse", reg_load, 0);
  endtask

  task automatic t_ret(input logic rs, input logic [12:0] pc, input logic cf, input logic zf);
    int lat; logic [7:0] s0, sp1; int w0;
    s0 = sp;
    issue(2'b01, rs, 2'b00, lat, sp1, w0);
    chk(sp1 == s0 + 8'd4, "R5 R8 sp first", sp1, s0 + 8'd4);
    chk(lat == 6, "R10 ret latency", lat, 6);
    chk(ret_load, "R5 ret_load", ret_load, 1);
    chk(ret_pc == pc, "R5 ret_pc", ret_pc, pc);
    chk(flags_load == rs, "R6 flags_load", flags_load, rs);
    if (rs) chk({ret_cf, ret_zf} == {cf, zf}, "R6 flags", {ret_cf, ret_zf}, {cf, zf});
    chk(wn == w0, "R5 no writes", wn - w0, 0);
  endtask

  task automatic t_illegal(input logic [1:0] k);
    logic [7:0] s0; int w0;
    s0 = sp;
    @(negedge clk);
    w0 = wn;
    op_valid = 1'b1; op_kind = k; op_sel = 2'b11;
    @(negedge clk);
    op_valid = 1'b0;
    chk(err && !busy, "R7 err pulse", {err, busy}, 2'b10);
    @(negedge clk);
    chk(!err, "R7 err one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk(wn == w0 && sp == s0 && !busy, "R7 no effect", {wn - w0, sp}, {32'd0, s0});
  endtask

  task automatic t_busy_ignore();
    logic [7:0] s0; int w0; int lat;
    s0 = sp;
    call_pc = 13'h0123; call_cf = 1'b0; call_zf = 1'b0;
    hl_in = 8'hEE;
    @(negedge clk);
    w0 = wn;
    op_valid = 1'b1; op_kind = 2'b00;
    @(negedge clk);
    chk(busy, "R9 busy", busy, 1);
    op_kind = 2'b10; op_sel = 2'b00;
    @(negedge clk);
    op_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    repeat (4) @(negedge clk);
    chk(wn - w0 == 4, "R9 ignored request writes", wn - w0, 4);
    chk(sp == s0 - 8'd4, "R9 ignored request sp", sp, s0 - 8'd4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_call(13'h1A5C, 1'b1, 1'b0);
    t_push(2'd0, 8'h3B);
    t_push(2'd2, 8'h7E);
    t_pop(2'd1, 8'h7E);
    t_pop(2'd0, 8'h3B);
    t_ret(1'b0, 13'h1A5C, 1'b1, 1'b0);
    chk(sp == 8'h02, "R8 sp wrapped back", sp, 8'h02);
    t_call(13'h0F31, 1'b0, 1'b1);
    t_ret(1'b1, 13'h0F31, 1'b0, 1'b1);
    t_illegal(2'b10);
    t_illegal(2'b11);
    t_busy_ignore();
    t_push(2'd1, 8'h5A);
    t_pop(2'd2, 8'h5A);
    t_ret(1'b0, 13'h0123, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule